// File: doc/BRIEF.md
# OFDM Preamble Timing Sequencer

This block tells the receive datapath where it is inside an OFDM preamble. A one-cycle detect pulse from the packet detector starts a 16-bit sample counter. The counter then advances once for each valid input sample. The preamble has a fixed layout:

- six short training symbols;
- a 32-sample cyclic prefix for the long symbols;
- two long training symbols;
- then the payload.

The block compares the counter against the start position of each of these sections. When a section starts, it raises a one-cycle start strobe and updates a registered phase code. The phase code holds its value until the next section boundary.

Downstream blocks use the phase code to gate their work on the right samples. For example, a correlator looks only at the short section and a channel estimator only at the long section. An abort input drops the sequencer back to idle at any time. A detect pulse that arrives while the payload phase is held starts a new packet.

The symbol lengths, the symbol counts and the counter width are parameters. The defaults are 16-sample short symbols and 64-sample long symbols. With these defaults the sections start at counts 0, 96, 128 and 256.

Top module: `pts_preamble_timer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the phase output is idle (code 0) and all four strobes are low.
- R2: A detect pulse taken while idle and without abort moves the phase to short (code 1) at the next edge, with a single-cycle short strobe. The detect cycle counts as sample 0.
- R3: When the 96th valid sample after the detect sample is taken (count 6 × short length), the phase becomes cyclic prefix (code 2) at that edge, and the prefix strobe is high for exactly that cycle.
- R4: At count 128 (prefix start + 32), the phase becomes long (code 3), and the long strobe is high for one cycle.
- R5: At count 256 (long start + 2 × long length), the phase becomes payload (code 4), and the payload strobe is high for one cycle. The payload phase then holds, with no further strobes, for any number of valid samples.
- R6: Cycles with the sample-valid input low do not advance the count. They produce no prefix, long or payload strobe, and they leave the phase unchanged.
- R7: Abort returns the phase to idle at the next edge, with no strobes, from any phase. Abort takes priority over a detect pulse in the same cycle. Valid samples after an abort leave the phase idle.
- R8: A detect pulse during the short, prefix or long phase is ignored. No short strobe is raised, and the later boundaries keep the timing of the original detect.
- R9: A detect pulse during the payload phase restarts the sequence exactly as in R2, with the count cleared.
- R10: At most one strobe is high in any cycle. The phase changes only together with a strobe, or when it returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| det_pulse | input | 1 | Packet detect event; this cycle is sample 0 |
| abort | input | 1 | Abandon the current packet and return to idle |
| phase_o | output | 3 | Phase: 0 idle, 1 short, 2 prefix, 3 long, 4 payload |
| stb_short_o | output | 1 | One-cycle start of the short section |
| stb_cpre_o | output | 1 | One-cycle start of the cyclic prefix |
| stb_long_o | output | 1 | One-cycle start of the long symbols |
| stb_pay_o | output | 1 | One-cycle start of the payload |

## Verification
An abort and a detect pulse can arrive in the same cycle. The bench raises both inputs together while the block is idle. The cycle is judged correct only if the phase stays idle and no short strobe appears. A second collision comes from a stray detect pulse in mid-sequence while samples keep flowing: the pulse must fall through without restarting the count. This is judged by requiring the prefix and long strobes to land at counts 96 and 128 of the original packet.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SHORT = 3'd1,
    PH_CPRE  = 3'd2,
    PH_LONG  = 3'd3,
    PH_PAY   = 3'd4
  } phase_t;

  // boundaries after the start point: prefix, long, payload
  localparam int NUM_MARKS = 3;

endpackage

// File: rtl/pts_sample_counter.sv
module pts_sample_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  assign cnt_next = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/pts_mark_decode.sv
module pts_mark_decode
  import pts_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_LEN = 16,
  parameter int SHORT_NUM = 6,
  parameter int CP_LEN    = 32,
  parameter int LONG_LEN  = 64,
  parameter int LONG_NUM  = 2
) (
  input  logic [CNT_W-1:0]     cnt_next,
  output logic [NUM_MARKS-1:0] hit
);

  localparam int CPRE_AT = SHORT_NUM * SHORT_LEN;
  localparam int LONG_AT = CPRE_AT + CP_LEN;
  localparam int PAY_AT  = LONG_AT + LONG_NUM * LONG_LEN;

  function automatic int mark_at(input int idx);
    case (idx)
      0:       mark_at = CPRE_AT;
      1:       mark_at = LONG_AT;
      default: mark_at = PAY_AT;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_MARKS; g++) begin : g_mark
    assign hit[g] = (cnt_next == CNT_W'(mark_at(g)));
  end

endmodule

// File: rtl/pts_phase_ctrl.sv
module pts_phase_ctrl
  import pts_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic                 det_pulse,
  input  logic                 abort,
  input  logic [NUM_MARKS-1:0] hit,
  output phase_t               phase_q,
  output logic [NUM_MARKS:0]   stb_q,
  output logic                 start,
  output logic                 run
);

  phase_t                 phase_d;
  logic   [NUM_MARKS:0]   stb_d;
  logic                   active;

  assign active = (phase_q == PH_SHORT) || (phase_q == PH_CPRE) || (phase_q == PH_LONG);
  assign start  = det_pulse && !abort && ((phase_q == PH_IDLE) || (phase_q == PH_PAY));
  assign run    = smp_valid && active && !abort;

  always_comb begin
    phase_d = phase_q;
    stb_d   = '0;
    if (abort) begin
      phase_d = PH_IDLE;
    end else if (start) begin
      phase_d  = PH_SHORT;
      stb_d[0] = 1'b1;
    end else if (run) begin
      case (phase_q)
        PH_SHORT: if (hit[0]) begin phase_d = PH_CPRE; stb_d[1] = 1'b1; end
        PH_CPRE:  if (hit[1]) begin phase_d = PH_LONG; stb_d[2] = 1'b1; end
        PH_LONG:  if (hit[2]) begin phase_d = PH_PAY;  stb_d[3] = 1'b1; end
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      stb_q   <= '0;
    end else begin
      phase_q <= phase_d;
      stb_q   <= stb_d;
    end
  end

endmodule

// File: rtl/pts_preamble_timer.sv
module pts_preamble_timer
  import pts_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_LEN = 16,
  parameter int SHORT_NUM = 6,
  parameter int CP_LEN    = 32,
  parameter int LONG_LEN  = 64,
  parameter int LONG_NUM  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_valid,
  input  logic       det_pulse,
  input  logic       abort,
  output logic [2:0] phase_o,
  output logic       stb_short_o,
  output logic       stb_cpre_o,
  output logic       stb_long_o,
  output logic       stb_pay_o
);

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     cnt_next;
  logic [NUM_MARKS-1:0] hit;
  logic [NUM_MARKS:0]   stb_q;
  phase_t               phase_q;
  logic                 start;
  logic                 run;

  pts_sample_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (start || abort),
    .run      (run),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  pts_mark_decode #(
    .CNT_W     (CNT_W),
    .SHORT_LEN (SHORT_LEN),
    .SHORT_NUM (SHORT_NUM),
    .CP_LEN    (CP_LEN),
    .LONG_LEN  (LONG_LEN),
    .LONG_NUM  (LONG_NUM)
  ) u_dec (
    .cnt_next (cnt_next),
    .hit      (hit)
  );

  pts_phase_ctrl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .det_pulse (det_pulse),
    .abort     (abort),
    .hit       (hit),
    .phase_q   (phase_q),
    .stb_q     (stb_q),
    .start     (start),
    .run       (run)
  );

  assign phase_o     = phase_q;
  assign stb_short_o = stb_q[0];
  assign stb_cpre_o  = stb_q[1];
  assign stb_long_o  = stb_q[2];
  assign stb_pay_o   = stb_q[3];

endmodule

// File: rtl/pts_preamble_timer_chk.sv
module pts_preamble_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_valid,
  input logic       det_pulse,
  input logic       abort,
  input logic [2:0] phase_o,
  input logic       stb_short_o,
  input logic       stb_cpre_o,
  input logic       stb_long_o,
  input logic       stb_pay_o
);

  logic [3:0] stbs;
  assign stbs = {stb_pay_o, stb_long_o, stb_cpre_o, stb_short_o};

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (det_pulse && !abort && phase_o == 3'd0) |=> (stb_short_o && phase_o == 3'd1));

  assert_cpre_order_R3: assert property (@(posedge clk) disable iff (rst)
    stb_cpre_o |-> ($past(phase_o) == 3'd1 && phase_o == 3'd2));

  assert_long_order_R4: assert property (@(posedge clk) disable iff (rst)
    stb_long_o |-> ($past(phase_o) == 3'd2 && phase_o == 3'd3));

  assert_pay_order_R5: assert property (@(posedge clk) disable iff (rst)
    stb_pay_o |-> ($past(phase_o) == 3'd3 && phase_o == 3'd4));

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !det_pulse && !abort) |=> (!stb_cpre_o && !stb_long_o && !stb_pay_o));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    abort |=> (phase_o == 3'd0 && stbs == 4'd0));

  assert_ignore_det_R8: assert property (@(posedge clk) disable iff (rst)
    (det_pulse && phase_o >= 3'd1 && phase_o <= 3'd3) |=> !stb_short_o);

  assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stbs));

  assert_phase_moves_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_o) |-> ((stbs != 4'd0) || phase_o == 3'd0));

endmodule

bind pts_preamble_timer pts_preamble_timer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .smp_valid   (smp_valid),
  .det_pulse   (det_pulse),
  .abort       (abort),
  .phase_o     (phase_o),
  .stb_short_o (stb_short_o),
  .stb_cpre_o  (stb_cpre_o),
  .stb_long_o  (stb_long_o),
  .stb_pay_o   (stb_pay_o)
);

// File: tb/pts_preamble_timer_test.sv
`timescale 1ns/1ps
module pts_preamble_timer_test;

  localparam int CPRE_AT = 6 * 16;
  localparam int LONG_AT = CPRE_AT + 32;
  localparam int PAY_AT  = LONG_AT + 2 * 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic       det_pulse = 1'b0;
  logic       abort = 1'b0;
  logic [2:0] phase_o;
  logic       stb_short_o, stb_cpre_o, stb_long_o, stb_pay_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pts_preamble_timer uut (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .det_pulse   (det_pulse),
    .abort       (abort),
    .phase_o     (phase_o),
    .stb_short_o (stb_short_o),
    .stb_cpre_o  (stb_cpre_o),
    .stb_long_o  (stb_long_o),
    .stb_pay_o   (stb_pay_o)
  );

  task automatic chk(input string req, input logic [2:0] ph, input logic [3:0] st);
    logic [3:0] got;
    got = {stb_pay_o, stb_long_o, stb_cpre_o, stb_short_o};
    n_chk++;
    if (phase_o !== ph || got !== st) begin
      n_bad++;
      $display("FAIL %s: phase=%0d strobes=%b expected phase=%0d strobes=%b",
               req, phase_o, got, ph, st);
    end
  endtask

  task automatic step(input logic v, input logic d, input logic a);
    @(negedge clk);
    smp_valid = v; det_pulse = d; abort = a;
    @(posedge clk);
    #1;
    smp_valid = 1'b0; det_pulse = 1'b0; abort = 1'b0;
  endtask

  function automatic logic [2:0] exp_ph(input int k);
    if (k < CPRE_AT) return 3'd1;
    if (k < LONG_AT) return 3'd2;
    if (k < PAY_AT)  return 3'd3;
    return 3'd4;
  endfunction

  function automatic logic [3:0] exp_st(input int k);
    if (k == CPRE_AT) return 4'b0010;
    if (k == LONG_AT) return 4'b0100;
    if (k == PAY_AT)  return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic string tag(input int k);
    if (k == CPRE_AT) return "R3";
    if (k == LONG_AT) return "R4";
    if (k >= PAY_AT)  return "R5";
    return "R2";
  endfunction

  // valid samples numbered lo..hi after the detect sample; gap inserts stall cycles
  task automatic advance(input int lo, input int hi, input bit gap);
    for (int k = lo; k <= hi; k++) begin
      if (gap) begin
        step(1'b0, 1'b0, 1'b0);
        chk("R6", exp_ph(k - 1), 4'b0000);
      end
      step(1'b1, 1'b0, 1'b0);
      chk(tag(k), exp_ph(k), exp_st(k));
    end
  endtask

  task automatic t_reset();
    chk("R1", 3'd0, 4'b0000);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", 3'd0, 4'b0000);
    step(1'b1, 1'b0, 1'b0);  // valid sample with no detect: still idle
    chk("R1", 3'd0, 4'b0000);
  endtask

  task automatic t_full();
    step(1'b1, 1'b1, 1'b0);
    chk("R2", 3'd1, 4'b0001);
    advance(1, PAY_AT + 8, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R5", 3'd4, 4'b0000);
  endtask

  task automatic t_restart_gaps();
    step(1'b1, 1'b1, 1'b0);
    chk("R9", 3'd1, 4'b0001);
    advance(1, PAY_AT, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R7", 3'd0, 4'b0000);
  endtask

  task automatic t_ignore_det();
    step(1'b1, 1'b1, 1'b0);
    chk("R2", 3'd1, 4'b0001);
    advance(1, 50, 1'b0);
    step(1'b1, 1'b1, 1'b0);  // stray detect: counted as sample 51
    chk("R8", 3'd1, 4'b0000);
    advance(52, 110, 1'b0);
    step(1'b1, 1'b1, 1'b0);  // stray detect in prefix: sample 111
    chk("R8", 3'd2, 4'b0000);
    advance(112, LONG_AT + 2, 1'b0);
  endtask

  task automatic t_abort_mid();
    step(1'b1, 1'b0, 1'b1);
    chk("R7", 3'd0, 4'b0000);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 1'b0);
      chk("R7", 3'd0, 4'b0000);
    end
  endtask

  task automatic t_abort_with_det();
    step(1'b1, 1'b1, 1'b1);
    chk("R7", 3'd0, 4'b0000);
    step(1'b1, 1'b0, 1'b0);
    chk("R7", 3'd0, 4'b0000);
    step(1'b1, 1'b1, 1'b0);
    chk("R2", 3'd1, 4'b0001);
    advance(1, CPRE_AT + 1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk("R7", 3'd0, 4'b0000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_full();
    t_restart_gaps();
    t_ignore_det();
    t_abort_mid();
    t_abort_with_det();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

endmodule